// File: doc/BRIEF.md
# One-Bit Symmetric FIR Decimation Stage

This block is the first decimation stage behind a one-bit sigma-delta modulator. Each modulator bit arrives with a strobe and is stored in a circular history. After every D accepted bits the block convolves the most recent L bits with a linear-phase low-pass response and emits one 24-bit two's complement sample. D and L are chosen by a three-bit rate code.

The response is symmetric, so only the first half of the taps is stored. Each stored coefficient is applied to the pair of samples that share it. The input is one bit wide, so a folded pair adds +2c, +c, 0, -c or -2c to the accumulator and no multiplier is needed. One 29-bit accumulator runs the L/2 pair steps on the fast system clock, one step per cycle, inside the decimation period. A sync input realigns the output phase and empties the convolution window.

Top module: `bitstream_fir_decimator`

## Requirements
- R1: Each cycle with `bitValid` high accepts `bitIn` as the newest sample. A 1 is weighted +1 and a 0 is weighted -1. Strobes are at least 4 clocks apart.
- R2: With e = min(rateCode, 5), the stage decimates by D = 4·2^e and uses L = 32·2^e taps, so codes 5, 6 and 7 all give D = 128 and L = 1024. The code is captured at reset and at each effective sync. A change of `rateIn` alone changes neither spacing nor length.
- R3: Only samples accepted since the last reset or effective sync take part. Taps whose age reaches back before that point add zero.
- R4: The tap of age k (0 = newest) has weight h(k) = h(L-1-k) = 1000·(k·1024/L + 1) for k < L/2.
- R5: After every D-th accepted bit, exactly one output is produced before the next bit arrives. Its value is the exact sum over the window of weight times sample, shifted right arithmetically by 5 bits (the upper 24 of 29 bits).
- R6: `outValid` is a single-cycle pulse, and `outWord` holds its value between pulses.
- R7: A rising edge of `syncIn` that is effective empties the window, restarts the D-bit count, drops any computation in progress and reloads the rate code. Holding `syncIn` high acts only once.
- R8: A rising edge of `syncIn` is ignored when a sync has already taken effect since reset and no bit has been accepted since the last D-bit boundary. Such an edge changes neither window nor rate.
- R9: Under reset, `outValid` and `outWord` are 0 and the window is empty. The sample storage itself is not reset.
- R10: The sum is kept at 29 bits with no intermediate truncation. A full 1024-tap window of all ones gives +8208000 and a window of all zeros gives -8208000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bitValid | input | 1 | Strobe marking a new modulator bit |
| bitIn | input | 1 | Modulator bit |
| rateIn | input | 3 | Rate code selecting decimation and length |
| syncIn | input | 1 | Synchronisation request, acts on its rising edge |
| outValid | output | 1 | One-cycle strobe for a new sample |
| outWord | output | 24 | Decimated sample, two's complement |

## Verification
The hardest case to reach from the ports is a sync edge that arrives exactly on a frame boundary of a block that is already synchronised. The bench counts accepted bits itself, lets the pending output finish, changes the rate code and then raises sync. The outputs that follow must keep the old rate and the growing window. A second difficult case is the full 1024-tap window at the top rate. There, new bits overwrite the oldest storage while the 512 pair steps are still running. Long runs of constant ones and zeros push the sum to its extremes.

// File: rtl/decim_pkg.sv
package decim_pkg;

  // strobes the sequencer hands to the datapath for one pair step
  typedef struct packed {
    logic first;   // first pair of a convolution (clears accumulator)
    logic accum;   // later pair steps
    logic last;    // final pair, result is registered to the output
    logic nearOk;  // newer sample of the pair lies inside the window
    logic farOk;   // older sample of the pair lies inside the window
  } step_ctrl_t;

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
#(
  parameter int MIN_DECIM_LOG = 2,
  parameter int TAP_RATIO_LOG = 3,
  parameter int RATE_SAT      = 5,
  parameter int RATE_W        = 3,
  localparam int MAX_LEN_LOG  = MIN_DECIM_LOG + TAP_RATIO_LOG + RATE_SAT,
  localparam int MAX_LEN      = 1 << MAX_LEN_LOG,
  localparam int AGE_W        = MAX_LEN_LOG,
  localparam int ADDR_W       = MAX_LEN_LOG - 1,
  localparam int PHASE_W      = MIN_DECIM_LOG + RATE_SAT,
  localparam int FILL_W       = MAX_LEN_LOG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              syncIn,
  input  logic [RATE_W-1:0] rateIn,
  output step_ctrl_t        ctrl,
  output logic [AGE_W-1:0]  ageNear,
  output logic [AGE_W-1:0]  ageFar,
  output logic [ADDR_W-1:0] coefAddr
);

  logic               syncPrev;
  logic               synced;
  logic [RATE_W-1:0]  curCode;
  logic [RATE_W-1:0]  rateSatIn;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] decimLast;
  logic [FILL_W-1:0]  fill;
  logic [FILL_W-1:0]  fillSnap;
  logic [FILL_W-1:0]  fillUse;
  logic               pend;
  logic               busy;
  logic [ADDR_W-1:0]  stepIdx;
  logic [ADDR_W-1:0]  kCur;
  logic [AGE_W-1:0]   halfLen;
  logic [AGE_W-1:0]   lenM1;
  logic               syncRise;
  logic               syncEvent;
  logic               stepNow;

  // rate decode: codes above the saturation point behave as the top code
  always_comb begin
    rateSatIn = (rateIn > RATE_W'(RATE_SAT)) ? RATE_W'(RATE_SAT) : rateIn;
    decimLast = PHASE_W'((1 << (MIN_DECIM_LOG + 32'(curCode))) - 1);
    halfLen   = AGE_W'(1 << (MIN_DECIM_LOG + TAP_RATIO_LOG - 1 + 32'(curCode)));
    lenM1     = AGE_W'((2 << (MIN_DECIM_LOG + TAP_RATIO_LOG - 1 + 32'(curCode))) - 1);
  end

  // a boundary-aligned edge on an already synchronised stage does nothing
  assign syncRise  = syncIn && !syncPrev;
  assign syncEvent = syncRise && !(synced && (phase == '0));

  // pair-step addressing
  always_comb begin
    kCur     = pend ? '0 : stepIdx;
    fillUse  = pend ? fill : fillSnap;
    ageNear  = {1'b0, kCur};
    ageFar   = lenM1 - ageNear;
    coefAddr = kCur << (RATE_SAT - 32'(curCode));
    stepNow  = (pend || busy) && !syncEvent;
    ctrl.first  = pend && !syncEvent;
    ctrl.accum  = busy && !syncEvent;
    ctrl.last   = stepNow && (ageNear == halfLen - 1'b1);
    ctrl.nearOk = {1'b0, ageNear} < fillUse;
    ctrl.farOk  = {1'b0, ageFar} < fillUse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncPrev <= 1'b0;
      synced   <= 1'b0;
      curCode  <= rateSatIn;
      phase    <= '0;
      fill     <= '0;
      fillSnap <= '0;
      pend     <= 1'b0;
      busy     <= 1'b0;
      stepIdx  <= '0;
    end else begin
      syncPrev <= syncIn;
      if (syncEvent) begin
        synced   <= 1'b1;
        curCode  <= rateSatIn;
        phase    <= PHASE_W'(bitValid);
        fill     <= FILL_W'(bitValid);
        pend     <= 1'b0;
        busy     <= 1'b0;
        stepIdx  <= '0;
      end else begin
        if (pend) begin
          pend     <= 1'b0;
          fillSnap <= fill;
          stepIdx  <= ADDR_W'(1);
          busy     <= !ctrl.last;
        end else if (busy) begin
          stepIdx <= stepIdx + 1'b1;
          if (ctrl.last) busy <= 1'b0;
        end
        if (bitValid) begin
          if (fill != FILL_W'(MAX_LEN)) fill <= fill + 1'b1;
          if (phase == decimLast) begin
            phase <= '0;
            pend  <= 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/decim_datapath.sv
module decim_datapath
  import decim_pkg::*;
#(
  parameter int MAX_LEN_LOG = 10,
  parameter int COEF_W      = 26,
  parameter int ACC_W       = 29,
  parameter int OUT_W       = 24,
  parameter int COEF_SCALE  = 1000,
  localparam int MAX_LEN    = 1 << MAX_LEN_LOG,
  localparam int HALF_MAX   = MAX_LEN / 2,
  localparam int AGE_W      = MAX_LEN_LOG,
  localparam int ADDR_W     = MAX_LEN_LOG - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitIn,
  input  step_ctrl_t        ctrl,
  input  logic [AGE_W-1:0]  ageNear,
  input  logic [AGE_W-1:0]  ageFar,
  input  logic [ADDR_W-1:0] coefAddr,
  output logic              outValid,
  output logic [OUT_W-1:0]  outWord
);

  // sample history: storage is deliberately left without reset
  logic              hist [MAX_LEN];
  logic [AGE_W-1:0]  wp;
  logic [AGE_W-1:0]  baseReg;
  logic [AGE_W-1:0]  baseCur;
  logic [AGE_W-1:0]  idxNear;
  logic [AGE_W-1:0]  idxFar;

  // half-response table, rising ramp computed at elaboration
  logic [COEF_W-1:0] coefRom [HALF_MAX];
  for (genvar j = 0; j < HALF_MAX; j++) begin : g_rom
    assign coefRom[j] = COEF_W'(COEF_SCALE * (j + 1));
  end

  logic signed [2:0]       signNear;
  logic signed [2:0]       signFar;
  logic signed [2:0]       pairSum;
  logic signed [ACC_W-1:0] coefExt;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sumNow;

  always_ff @(posedge clk) begin
    if (bitValid) hist[wp] <= bitIn;
  end

  always_comb begin
    baseCur = ctrl.first ? (wp - 1'b1) : baseReg;
    idxNear = baseCur - ageNear;
    idxFar  = baseCur - ageFar;
    signNear = ctrl.nearOk ? (hist[idxNear] ? 3'sb001 : 3'sb111) : 3'sb000;
    signFar  = ctrl.farOk  ? (hist[idxFar]  ? 3'sb001 : 3'sb111) : 3'sb000;
    pairSum  = signNear + signFar;
    coefExt  = $signed({{(ACC_W - COEF_W){1'b0}}, coefRom[coefAddr]});
    case (pairSum)
      3'sb010: term = coefExt <<< 1;
      3'sb001: term = coefExt;
      3'sb111: term = -coefExt;
      3'sb110: term = -(coefExt <<< 1);
      default: term = '0;
    endcase
    sumNow = ctrl.first ? term : (acc + term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      baseReg  <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      if (bitValid) wp <= wp + 1'b1;
      if (ctrl.first) baseReg <= wp - 1'b1;
      if (ctrl.first || ctrl.accum) acc <= sumNow;
      outValid <= ctrl.last;
      if (ctrl.last) outWord <= OUT_W'(sumNow >>> (ACC_W - OUT_W));
    end
  end

endmodule

// File: rtl/bitstream_fir_decimator.sv
module bitstream_fir_decimator
  import decim_pkg::*;
#(
  parameter int MIN_DECIM_LOG = 2,
  parameter int TAP_RATIO_LOG = 3,
  parameter int RATE_SAT      = 5,
  parameter int RATE_W        = 3,
  parameter int COEF_W        = 26,
  parameter int ACC_W         = 29,
  parameter int OUT_W         = 24,
  parameter int COEF_SCALE    = 1000,
  localparam int MAX_LEN_LOG  = MIN_DECIM_LOG + TAP_RATIO_LOG + RATE_SAT,
  localparam int AGE_W        = MAX_LEN_LOG,
  localparam int ADDR_W       = MAX_LEN_LOG - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              syncIn,
  output logic              outValid,
  output logic [OUT_W-1:0]  outWord
);

  step_ctrl_t        ctrl;
  logic [AGE_W-1:0]  ageNear;
  logic [AGE_W-1:0]  ageFar;
  logic [ADDR_W-1:0] coefAddr;

  decim_ctrl #(
    .MIN_DECIM_LOG(MIN_DECIM_LOG),
    .TAP_RATIO_LOG(TAP_RATIO_LOG),
    .RATE_SAT     (RATE_SAT),
    .RATE_W       (RATE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .syncIn   (syncIn),
    .rateIn   (rateIn),
    .ctrl     (ctrl),
    .ageNear  (ageNear),
    .ageFar   (ageFar),
    .coefAddr (coefAddr)
  );

  decim_datapath #(
    .MAX_LEN_LOG(MAX_LEN_LOG),
    .COEF_W     (COEF_W),
    .ACC_W      (ACC_W),
    .OUT_W      (OUT_W),
    .COEF_SCALE (COEF_SCALE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .ctrl     (ctrl),
    .ageNear  (ageNear),
    .ageFar   (ageFar),
    .coefAddr (coefAddr),
    .outValid (outValid),
    .outWord  (outWord)
  );

endmodule

// File: rtl/bitstream_fir_decimator_checker.sv
module bitstream_fir_decimator_checker
  import decim_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bitValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outWord,
  input step_ctrl_t       ctrl
);

  // R1: input strobes never come back to back
  a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    bitValid |=> !bitValid);

  // R3: an older sample is never inside the window while a newer one is outside
  a_r3_window_order: assert property (@(posedge clk) disable iff (rst)
    ctrl.farOk |-> ctrl.nearOk);

  // R5: the closing pair step is always part of an active convolution
  a_r5_last_in_run: assert property (@(posedge clk) disable iff (rst)
    ctrl.last |-> (ctrl.first || ctrl.accum));

  // R5: an output strobe follows the closing pair step
  a_r5_out_after_last: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(ctrl.last));

  // R6: one-cycle strobe
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6: the word holds between strobes
  a_r6_word_holds: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outWord));

  // R9: nothing is emitted in the first cycle after reset
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

endmodule

bind bitstream_fir_decimator bitstream_fir_decimator_checker #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitValid (bitValid),
  .outValid (outValid),
  .outWord  (outWord),
  .ctrl     (ctrl)
);

// File: tb/bitstream_fir_decimator_test.sv
module bitstream_fir_decimator_test;

  localparam int SCALE  = 1000;
  localparam int SHIFT  = 5;
  localparam int MAXLEN = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [2:0]  rateIn = 3'd0;
  logic        syncIn = 1'b0;
  logic        outValid;
  logic [23:0] outWord;

  always #10 clk = ~clk;

  bitstream_fir_decimator uut (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .rateIn(rateIn), .syncIn(syncIn), .outValid(outValid), .outWord(outWord)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int qVal[$];
  string qTag[$];

  // reference model state
  logic [MAXLEN-1:0] histB = '0;
  int mFill = 0, mPhase = 0, mCode = 0;
  bit mSynced = 0;
  string tagNote = "R5";
  logic [15:0] lfsr = 16'hACE1;

  function automatic int satCode(int c);
    return (c > 5) ? 5 : c;
  endfunction

  function automatic int decimOf();
    return 4 << mCode;
  endfunction

  function automatic int expectedWord();
    int len, sum;
    len = 8 * decimOf();
    sum = 0;
    for (int m = 0; m < len; m++) begin
      if (m < mFill) begin
        int k, h;
        k = (m < len / 2) ? m : len - 1 - m;
        h = SCALE * (k * (MAXLEN / len) + 1);
        sum += histB[m] ? h : -h;
      end
    end
    return sum >>> SHIFT;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one bit plus three idle cycles, expected output pushed on the D-th bit
  task automatic sendBit(input logic b);
    @(negedge clk);
    bitIn = b;
    bitValid = 1'b1;
    histB = {histB[MAXLEN-2:0], b};
    if (mFill < MAXLEN) mFill++;
    mPhase++;
    if (mPhase == decimOf()) begin
      mPhase = 0;
      qVal.push_back(expectedWord());
      qTag.push_back((mFill < 8 * decimOf()) ? {tagNote, " R3 partial window"} : {tagNote, " full window"});
    end
    @(negedge clk);
    bitValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendLfsr(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit(lfsr[0]);
    end
  endtask

  task automatic sendConst(input int n, input logic b);
    for (int i = 0; i < n; i++) sendBit(b);
  endtask

  task automatic modelSyncEdge();
    if (!(mSynced && mPhase == 0)) begin
      mFill = 0;
      mPhase = 0;
      mCode = satCode(int'(rateIn));
      mSynced = 1;
    end
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncIn = 1'b1;
    modelSyncEdge();
    @(negedge clk);
    syncIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each strobe
  logic [23:0] lastWord = '0;
  bit prevValid = 0;
  int pulseFail = 0;
  int holdFail = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (prevValid) pulseFail++;
        if (qVal.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R5 unexpected output: actual %0d expected none", int'($signed(outWord)));
        end else begin
          int ev;
          string tg;
          ev = qVal.pop_front();
          tg = qTag.pop_front();
          check(tg, int'($signed(outWord)), ev);
        end
        lastWord = outWord;
      end else if (outWord !== lastWord) begin
        holdFail++;
      end
      prevValid = outValid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mCode = satCode(int'(rateIn));
    repeat (3) @(negedge clk);
    check("R9 reset outValid", int'(outValid), 0);
    check("R9 reset outWord", int'(outWord), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R4 R5: code 0, window filling then full
    tagNote = "R4 R5";
    sendLfsr(60);

    // R2: rate change without sync keeps the old rate
    rateIn = 3'd2;
    tagNote = "R2 held rate";
    sendLfsr(8);

    // first sync after reset takes effect: code 2
    waitIdle(40);
    tagNote = "R7 first sync";
    pulseSync();
    sendLfsr(100);

    // R7: mid-frame sync held high acts once
    sendLfsr(3);
    waitIdle(100);
    tagNote = "R7 held sync";
    @(negedge clk);
    syncIn = 1'b1;
    modelSyncEdge();
    sendLfsr(40);
    syncIn = 1'b0;

    // R8: boundary-aligned sync ignored, rate change not loaded
    sendLfsr(8);
    waitIdle(100);
    rateIn = 3'd0;
    tagNote = "R8 ignored sync";
    pulseSync();
    sendLfsr(32);

    // R2 R10: code 7 behaves as top rate, all ones saturating window
    sendLfsr(1);
    waitIdle(100);
    rateIn = 3'd7;
    tagNote = "R2 R10 ones";
    pulseSync();
    sendConst(1100, 1'b1);
    waitIdle(600);

    // R2 R10: code 6, all zeros
    rateIn = 3'd6;
    tagNote = "R2 R10 zeros";
    pulseSync();
    sendConst(1100, 1'b0);
    waitIdle(600);

    check("R10 bench top value", expectedWord(), -8208000);
    check("R5 all outputs delivered", qVal.size(), 0);
    check("R6 single-cycle strobe", pulseFail, 0);
    check("R6 word held between strobes", holdFail, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule